// File: doc/BRIEF.md
# Bit-Oriented Data Link Message Receiver

This block watches the one-bit data link stream that a T1 framer extracts and hunts for repeating 16-bit bit-oriented codewords. A codeword, in transmission order, is a zero, six message bits with the most significant first, another zero, and then eight ones. Each accepted codeword has its six-bit message stored as an octet in one of two alternating receive buffers. A read-only pointer tells software which buffer holds the newest message.

A programmable repetition limit raises an end-of-transfer event once the same message has arrived that many times in a row. A limit of zero means reception runs forever with no such event. The block also flags an abort, which is a long run of ones after codeword traffic. It flags HDLC idle flags, which show that the link carries message-oriented traffic. The three status bits drive one interrupt output through individual enables. A global mode bit chooses whether a status read clears them or whether software must write ones to clear them.

Software reaches everything through a small register port. Address 0 holds the limit in bits 6..0 and the read-only buffer pointer in bit 7. Address 1 holds status: idle in bit 0, abort in bit 1 and end-of-transfer in bit 2. Address 2 holds the enables in bits 2..0 and the clear-mode bit in bit 7. Addresses 3 and 4 read buffer 0 and buffer 1.

Top module: `dl_bitmsg_rx`

## Requirements
- R1: A codeword is accepted when the last 16 valid bits (dl_valid high) are 0, d5..d0, 0, 1111_1111 in arrival order. Cycles with dl_valid low are skipped. The message is stored as {0,d5..d0,0}, readable at address 3 (buffer 0) or 4 (buffer 1).
- R2: Pointer bit 7 of address 0 names the buffer holding the newest message. It resets to 1, so the first message lands in buffer 0, and it toggles on every store. Writes to it have no effect.
- R3: With a nonzero limit L in address 0 bits 6..0, status bit 2 (end-of-transfer) sets when the same message has been accepted L times in a row. The count then restarts, so L more are needed for the next event.
- R4: An accepted message that differs from the previous one restarts the repetition count at one.
- R5: With limit 0, status bit 2 is never set, however many codewords arrive.
- R6: After at least one accepted codeword, 16 consecutive ones set status bit 1 (abort). After an abort, further ones do not set it again until a new codeword is accepted.
- R7: The octet 0111_1110 sets status bit 0 (idle flag) while the block is not locked to codewords. While locked, the same pattern inside a codeword carrying message 0x3F does not set it.
- R8: irq is high exactly when some status bit is set and its enable (address 2, same bit position) is 1. All enables reset to 0.
- R9: With address 2 bit 7 = 0, writing 1 to a status bit at address 1 clears it. With bit 7 = 1, reading address 1 clears all status bits and writes to address 1 have no effect. A new event in the same cycle wins over clearing.
- R10: Once locked, the next codeword must end exactly 16 valid bits after the previous one. A misaligned stream drops the lock and the block hunts again, accepting the next whole codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_bit | input | 1 | Data link bit |
| dl_valid | input | 1 | dl_bit carries a new link bit this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt output |

## Verification
A wrong repetition count shows up at the status port and on irq at the codeword that should have, or should not have, completed the run. That is at most one codeword (16 link bits) late. A broken pointer or buffer steering shows on the very next store, because the newest message appears under the wrong address. Lost or false lock shows only as a missing or spurious store, or as an idle flag inside a 0x3F codeword. Sticky-status faults show on the first read after the clearing access.

// File: rtl/dl_bitmsg_rx.sv
module dl_bitmsg_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dl_bit,
  input  logic       dl_valid,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam logic [2:0] CFG_A = 3'd0, ST_A = 3'd1, IEN_A = 3'd2, BUF0_A = 3'd3, BUF1_A = 3'd4;
  localparam int CNT_W = 7;

  logic [14:0]      sr;
  logic             lock, have_cw, ptr, cor;
  logic [3:0]       slot;
  logic [5:0]       last_msg;
  logic [CNT_W-1:0] reps, limit;
  logic [7:0]       buf0, buf1;
  logic [2:0]       st, ien;

  wire [15:0] nxt = {sr, dl_bit};
  wire [5:0]  msg = nxt[14:9];
  wire cw_hit   = dl_valid && !nxt[15] && !nxt[8] && nxt[7:0] == 8'hFF;
  wire at_slot  = slot == 4'd15;
  wire acc      = cw_hit && (!lock || at_slot);
  wire abort_ev = dl_valid && have_cw && (&nxt);
  wire idle_ev  = dl_valid && !lock && nxt[7:0] == 8'h7E;
  wire [CNT_W-1:0] reps_n = (have_cw && msg == last_msg) ? reps + 7'd1 : 7'd1;
  wire eot_ev   = acc && limit != '0 && reps_n >= limit;
  wire [2:0] ev = {eot_ev, abort_ev, idle_ev};
  wire st_hit   = reg_addr == ST_A;
  wire [2:0] clr = (cor && reg_rd && st_hit) ? 3'b111 :
                   (!cor && reg_wr && st_hit) ? reg_wdata[2:0] : 3'b000;

  assign irq = |(st & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; lock <= 1'b0; have_cw <= 1'b0; slot <= '0;
      last_msg <= '0; reps <= '0; limit <= '0; ptr <= 1'b1;
      buf0 <= '0; buf1 <= '0; st <= '0; ien <= '0; cor <= 1'b0;
    end else begin
      if (dl_valid) begin
        sr   <= nxt[14:0];
        slot <= slot + 4'd1;
      end
      if (acc) begin
        lock     <= 1'b1;
        have_cw  <= 1'b1;
        slot     <= '0;
        last_msg <= msg;
        reps     <= eot_ev ? '0 : reps_n;
        ptr      <= ~ptr;
        if (ptr) buf0 <= {1'b0, msg, 1'b0};
        else     buf1 <= {1'b0, msg, 1'b0};
      end else if (abort_ev) begin
        lock    <= 1'b0;
        have_cw <= 1'b0;
        reps    <= '0;
      end else if (dl_valid && lock && at_slot) begin
        lock <= 1'b0;
      end
      st <= (st & ~clr) | ev;
      if (reg_wr) begin
        case (reg_addr)
          CFG_A: limit <= reg_wdata[6:0];
          IEN_A: begin ien <= reg_wdata[2:0]; cor <= reg_wdata[7]; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      CFG_A:   reg_rdata = {ptr, limit};
      ST_A:    reg_rdata = {5'b0, st};
      IEN_A:   reg_rdata = {cor, 4'b0, ien};
      BUF0_A:  reg_rdata = buf0;
      BUF1_A:  reg_rdata = buf1;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module dl_bitmsg_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [2:0] reg_addr,
  input logic       acc,
  input logic       ptr,
  input logic       cor,
  input logic [6:0] limit,
  input logic [2:0] st,
  input logic [2:0] ev
);
  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ptr != $past(ptr));
  // R2
  ptr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !acc) |=> $stable(ptr));
  // R5
  eot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == 7'd0 && !st[2]) |=> !st[2]);
  // R6
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[1] && !(reg_addr == 3'd1 && (reg_wr || reg_rd))) |=> st[1]);
  // R9
  cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cor && reg_rd && reg_addr == 3'd1 && ev == 3'b000) |=> st == 3'b000);
endmodule

bind dl_bitmsg_rx dl_bitmsg_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .acc(acc), .ptr(ptr), .cor(cor), .limit(limit), .st(st), .ev(ev)
);

// File: tb/dl_bitmsg_rx_bench.sv
`timescale 1ns/1ps
module dl_bitmsg_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, dl_bit = 1'b0, dl_valid = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int vectors = 0, miscompares = 0;
  logic exp_ptr = 1'b1;
  logic [7:0] d;

  dl_bitmsg_rx u_dl_bitmsg_rx (.*);

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, bit gap = 0);
    dl_bit = b; dl_valid = 1'b1;
    @(negedge clk);
    dl_valid = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic send_cw(logic [5:0] m, bit gap = 0);
    logic [15:0] w;
    w = {1'b0, m, 1'b0, 8'hFF};
    for (int i = 15; i >= 0; i--) send_bit(w[i], gap);
    exp_ptr = ~exp_ptr;
  endtask

  task automatic send_ones(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    rd(0, d); check("R2 reset pointer", d, 8'h80);
    rd(1, d); check("R9 reset status", d, 8'h00);
    rd(2, d); check("R8 reset enables", d, 8'h00);
    check("R8 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_store;
    send_cw(6'h2D);
    rd(3, d); check("R1 buffer0 octet", d, 8'h5A);
    rd(0, d); check("R2 pointer after first", d, 8'h00);
    send_cw(6'h13, 1);
    rd(4, d); check("R1 buffer1 octet with gaps", d, 8'h26);
    rd(3, d); check("R1 buffer0 kept", d, 8'h5A);
    rd(0, d); check("R2 pointer after second", d, 8'h80);
  endtask

  task automatic t_ptr_ro;
    wr(0, 8'h00);
    rd(0, d); check("R2 pointer write ignored", d[7:7], exp_ptr);
  endtask

  task automatic t_limit;
    wr(2, 8'h04); wr(0, 8'h03);
    send_cw(6'h21); send_cw(6'h21);
    rd(1, d); check("R3 no eot after two", d, 8'h00);
    check("R8 irq low before eot", {7'b0, irq}, 8'h00);
    send_cw(6'h21);
    rd(1, d); check("R3 eot after three", d, 8'h04);
    check("R8 irq on eot", {7'b0, irq}, 8'h01);
    wr(1, 8'h04);
    rd(1, d); check("R9 write-one clears eot", d, 8'h00);
    send_cw(6'h21); send_cw(6'h21);
    rd(1, d); check("R3 count restarted", d, 8'h00);
    send_cw(6'h21);
    rd(1, d); check("R3 second eot", d, 8'h04);
    wr(1, 8'h04);
  endtask

  task automatic t_restart;
    send_cw(6'h0A); send_cw(6'h0A); send_cw(6'h35); send_cw(6'h35);
    rd(1, d); check("R4 new message restarts count", d, 8'h00);
    send_cw(6'h35);
    rd(1, d); check("R4 eot on third of new message", d, 8'h04);
    wr(1, 8'h04);
  endtask

  task automatic t_zero;
    wr(0, 8'h00);
    for (int i = 0; i < 5; i++) send_cw(6'h11);
    rd(1, d); check("R5 limit zero never ends", d, 8'h00);
    check("R5 irq quiet", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_lock;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_cw(6'h1C);
    rd(0, d); check("R10 pointer after realign", d[7:7], exp_ptr);
    rd(exp_ptr ? 3'd4 : 3'd3, d); check("R10 realigned codeword stored", d, 8'h38);
  endtask

  task automatic t_idle_locked;
    send_cw(6'h3F);
    rd(1, d); check("R7 no idle inside locked 0x3F codeword", d, 8'h00);
    rd(exp_ptr ? 3'd4 : 3'd3, d); check("R1 0x3F stored", d, 8'h7E);
  endtask

  task automatic t_abort;
    wr(2, 8'h02);
    send_ones(7);
    rd(1, d); check("R6 fifteen ones no abort", d, 8'h00);
    check("R8 irq low", {7'b0, irq}, 8'h00);
    send_ones(1);
    rd(1, d); check("R6 sixteen ones abort", d, 8'h02);
    check("R8 irq on abort", {7'b0, irq}, 8'h01);
    wr(1, 8'h02);
    rd(1, d); check("R9 write-one clears abort", d, 8'h00);
    send_ones(20);
    rd(1, d); check("R6 abort not rearmed", d, 8'h00);
  endtask

  task automatic t_idle_cor;
    logic [7:0] f;
    f = 8'h7E;
    wr(2, 8'h81);
    for (int i = 7; i >= 0; i--) send_bit(f[i]);
    check("R8 irq on idle", {7'b0, irq}, 8'h01);
    rd(1, d); check("R7 idle flag seen", d, 8'h01);
    rd(1, d); check("R9 read cleared status", d, 8'h00);
    check("R8 irq cleared by read", {7'b0, irq}, 8'h00);
    for (int i = 7; i >= 0; i--) send_bit(f[i]);
    wr(1, 8'h01);
    rd(1, d); check("R9 write ignored in read-clear mode", d, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_store; t_ptr_ro; t_limit; t_restart; t_zero;
    t_lock; t_idle_locked; t_abort; t_idle_cor;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule